// File: doc/BRIEF.md
# SPI Target with Status-Byte FIFOs

This block is a full-duplex SPI target peripheral in SPI mode 0. Every byte the controller clocks in is stored in a receive FIFO. At the same time one byte is clocked out. That byte comes from a transmit FIFO, or, when the transmit FIFO is empty or disabled, from a status byte that software sets. This lets firmware run software flow control: the controller keeps clocking, and it sees "busy" or "ready" codes until real reply bytes appear in the transmit FIFO.

The system side is a small register file on a byte-wide read/write strobe bus. One interrupt line combines:
- a receive-level condition, true while the fill count is strictly above a threshold;
- a sticky end-of-transaction flag;
- sticky overflow and underflow flags.

When chip select is released, the block empties the transmit FIFO by copying its read pointer into its write pointer. As a result, a new transaction never starts with bytes left over from an aborted one. Received bytes stay readable after the release.

The SPI pins are oversampled in the system clock domain. SCLK must run at most about one eighth of the system clock rate.

Top module: `spi_target_fifo`

## Requirements
- R1: Mode 0 receive: MOSI is sampled on rising SCLK, MSB first. Each complete byte goes into the RX FIFO, which is read in order through address 0.
- R2: Software writes to address 0 push bytes into the TX FIFO. Each byte is sent on MISO MSB first, one byte out for each byte in, and the first bit is valid before the first rising SCLK after chip select falls.
- R3: When the TX FIFO is empty, the byte sent is the status byte held at address 2 (reset value 0xFF).
- R4: Status bit 0 is 1 exactly while the RX count (address 7) is strictly greater than the threshold at address 3 (reset value 7). With a threshold of 7, the eighth byte sets it.
- R5: Chip-select release sets status bit 1 (address 4), which stays set until software writes a 1 to bit 1 of address 5.
- R6: On chip-select release the TX FIFO becomes empty, with the write pointer equal to the read pointer. The next transaction starts with the status byte, and RX data stays readable.
- R7: A partial byte at chip-select release is dropped, and the next transaction starts with bit count zero.
- R8: Address 1 bit 0 enables RX and bit 1 enables TX (both 1 at reset). With RX disabled, incoming bytes are dropped. With TX disabled, writes to address 0 are ignored and the status byte is sent.
- R9: The TX read pointer (address 8) and write pointer (address 9) are 7-bit registers that software can read and write. They set which stored byte is sent next.
- R10: The FIFOs hold 64 entries. Status bit 2 is set when a byte arrives at a full RX FIFO, and that byte is dropped. Bit 3 is set when address 0 is read with the RX FIFO empty. Bit 4 is set when a byte is written to a full TX FIFO. Bit 5 is set when a byte is loaded with TX enabled and the TX FIFO empty. Bits 1 to 5 are cleared by writing 1 to the same bit of address 5.
- R11: irq is the OR of the status bits ANDed with the enable mask at address 6 (reset value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, low while deselected |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX at address 0) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the TX pointers become equal after each chip-select release;
- the RX fill count never goes past the depth;
- a byte that arrives while the RX FIFO is full leaves the write pointer unchanged;
- the end-of-transaction flag stays set until it is cleared;
- the bit counter restarts;
- an enabled receive-level condition always drives irq.

Other behaviour can only be shown by the bench's SPI scenarios:
- the serial byte order;
- the substitution of the status byte;
- the exact byte on which the threshold is crossed;
- a partial byte being dropped;
- the effect of each enable bit;
- a reply that resumes at a pointer written by software.

// File: rtl/spi_target_fifo.sv
module spi_target_fifo #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [2:0] sck_q, cs_q;
  logic [1:0] mo_q;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] rx_mem [DEPTH];
  logic [7:0] tx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp, tx_wp, tx_rp, thr;
  logic [1:0] ctl;
  logic [7:0] dflt;
  logic [5:0] ien;
  logic [5:1] flags;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_act   = ~cs_q[1];
  wire cs_start = ~cs_q[1] & cs_q[2];
  wire cs_end   = cs_q[1] & ~cs_q[2];

  wire [PW-1:0] rx_cnt = rx_wp - rx_rp;
  wire [PW-1:0] tx_cnt = tx_wp - tx_rp;
  wire rx_full  = rx_cnt == PW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == PW'(DEPTH);
  wire tx_empty = tx_cnt == '0;

  wire [7:0] rx_byte  = {rx_sh, mo_q[1]};
  wire byte_done = cs_act & sck_rise & (bitcnt == 3'd7);
  wire load      = cs_start | (cs_act & sck_fall & (bitcnt == 3'd0));
  wire tx_pop    = load & ctl[1] & ~tx_empty;
  wire rx_push   = byte_done & ctl[0] & ~rx_full;

  wire wr_data = reg_we & (reg_addr == 4'd0);
  wire wr_clr  = reg_we & (reg_addr == 4'd5);
  wire wr_rp   = reg_we & (reg_addr == 4'd8);
  wire wr_wp   = reg_we & (reg_addr == 4'd9);
  wire rd_data = reg_re & (reg_addr == 4'd0);
  wire tx_push = wr_data & ctl[1] & ~tx_full;

  wire [5:1] flag_set = {load & ctl[1] & tx_empty,
                         wr_data & ctl[1] & tx_full,
                         rd_data & rx_empty,
                         byte_done & ctl[0] & rx_full,
                         cs_end};
  wire [5:0] status = {flags, rx_cnt > thr};

  assign miso = ~cs_n & tx_sh[7];
  assign irq  = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mo_q   <= '0;
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      mo_q  <= {mo_q[0], mosi};
      if (cs_end) bitcnt <= '0;
      else if (cs_act & sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        rx_sh  <= rx_byte[6:0];
      end
      if (load) tx_sh <= tx_pop ? tx_mem[tx_rp[AW-1:0]] : dflt;
      else if (cs_act & sck_fall) tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rx_byte;
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
      tx_wp <= '0;
      tx_rp <= '0;
      ctl   <= 2'b11;
      dflt  <= 8'hFF;
      thr   <= PW'(7);
      ien   <= '0;
      flags <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_data & ~rx_empty) rx_rp <= rx_rp + 1'b1;
      if (cs_end) tx_wp <= tx_rp;
      else if (wr_wp) tx_wp <= reg_wdata[PW-1:0];
      else if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (wr_rp) tx_rp <= reg_wdata[PW-1:0];
      else if (tx_pop) tx_rp <= tx_rp + 1'b1;
      if (reg_we && reg_addr == 4'd1) ctl  <= reg_wdata[1:0];
      if (reg_we && reg_addr == 4'd2) dflt <= reg_wdata;
      if (reg_we && reg_addr == 4'd3) thr  <= reg_wdata[PW-1:0];
      if (reg_we && reg_addr == 4'd6) ien  <= reg_wdata[5:0];
      flags <= (flags & ~(wr_clr ? reg_wdata[5:1] : 5'd0)) | flag_set;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = rx_empty ? 8'h00 : rx_mem[rx_rp[AW-1:0]];
      4'd1:    reg_rdata = {6'd0, ctl};
      4'd2:    reg_rdata = dflt;
      4'd3:    reg_rdata = 8'(thr);
      4'd4:    reg_rdata = {2'd0, status};
      4'd6:    reg_rdata = {2'd0, ien};
      4'd7:    reg_rdata = 8'(rx_cnt);
      4'd8:    reg_rdata = 8'(tx_rp);
      4'd9:    reg_rdata = 8'(tx_wp);
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r6_flush_empties_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end && !wr_rp |=> tx_wp == tx_rp);
  a_r10_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= PW'(DEPTH));
  a_r10_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_full |=> $stable(rx_wp));
  a_r5_cs_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !(wr_clr && reg_wdata[1]) |=> status[1]);
  a_r7_bitcnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> bitcnt == 3'd0);
  a_r4_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ien[0] && (rx_cnt > thr) |-> irq);
endmodule

// File: tb/sim_spi_target_fifo.sv
module sim_spi_target_fifo;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, irq;
  logic reg_we = 0, reg_re = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  int n_chk = 0, n_bad = 0;

  spi_target_fifo u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic cs_lo;
    @(negedge clk); cs_n = 0; #100;
  endtask

  task automatic cs_hi;
    #80 cs_n = 1; #100; @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b]; #80; i[b] = miso; sclk = 1; #80; sclk = 0;
    end
  endtask

  task automatic xbits(input int n);
    for (int b = 0; b < n; b++) begin
      mosi = b[0]; #80; sclk = 1; #80; sclk = 0;
    end
  endtask

  task automatic drain;
    logic [7:0] c, d;
    rd(4'd7, c);
    for (int k = 0; k < c; k++) rd(4'd0, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'd4, d); chk("R10 status at reset", d, 8'h00);
    rd(4'd7, d); chk("R4 rx count at reset", d, 8'h00);
    rd(4'd2, d); chk("R3 status byte reset", d, 8'hFF);
    rd(4'd3, d); chk("R4 threshold reset", d, 8'h07);
    rd(4'd1, d); chk("R8 enables reset", d, 8'h03);
    chk("R11 irq at reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    wr(4'd2, 8'h5A); wr(4'd0, 8'hA5); wr(4'd0, 8'h3C);
    cs_lo;
    xfer(8'h81, d); chk("R2 first tx byte", d, 8'hA5);
    xfer(8'h7E, d); chk("R2 second tx byte", d, 8'h3C);
    xfer(8'h00, d); chk("R3 empty tx sends status byte", d, 8'h5A);
    cs_hi;
    rd(4'd7, d); chk("R6 rx kept after release", d, 8'h03);
    rd(4'd0, d); chk("R1 rx byte 0", d, 8'h81);
    rd(4'd0, d); chk("R1 rx byte 1", d, 8'h7E);
    rd(4'd0, d); chk("R1 rx byte 2", d, 8'h00);
  endtask

  task automatic t_thresh;
    logic [7:0] d;
    wr(4'd6, 8'h01);
    cs_lo;
    for (int k = 0; k < 7; k++) xfer(8'(k + 1), d);
    rd(4'd4, d); chk("R4 level clear at 7 bytes", d & 8'h01, 8'h00);
    chk("R11 irq low at 7 bytes", {7'd0, irq}, 8'h00);
    xfer(8'h08, d);
    rd(4'd4, d); chk("R4 level set at 8 bytes", d & 8'h01, 8'h01);
    chk("R11 irq high at 8 bytes", {7'd0, irq}, 8'h01);
    cs_hi;
    drain;
    rd(4'd4, d); chk("R4 level clear after drain", d & 8'h01, 8'h00);
    wr(4'd6, 8'h00);
  endtask

  task automatic t_flush;
    logic [7:0] d, p;
    wr(4'd5, 8'h3E);
    wr(4'd0, 8'h11); wr(4'd0, 8'h22); wr(4'd0, 8'h33); wr(4'd0, 8'h44);
    cs_lo; xfer(8'hE1, d); chk("R2 aborted txn first byte", d, 8'h11); cs_hi;
    rd(4'd8, p); rd(4'd9, d); chk("R6 pointers equal after release", d, p);
    cs_lo; xfer(8'hE2, d); chk("R6 no leftover byte", d, 8'h5A); cs_hi;
    drain;
  endtask

  task automatic t_cs_flag;
    logic [7:0] d;
    rd(4'd4, d); chk("R5 release flag set", d & 8'h02, 8'h02);
    chk("R11 flag masked", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'h02);
    chk("R11 flag enabled", {7'd0, irq}, 8'h01);
    wr(4'd5, 8'h02);
    rd(4'd4, d); chk("R5 flag cleared", d & 8'h02, 8'h00);
    chk("R11 irq after clear", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'h00);
  endtask

  task automatic t_partial;
    logic [7:0] d;
    cs_lo; xbits(4); cs_hi;
    rd(4'd7, d); chk("R7 partial byte dropped", d, 8'h00);
    cs_lo; xfer(8'hC3, d); cs_hi;
    rd(4'd0, d); chk("R7 aligned after partial", d, 8'hC3);
  endtask

  task automatic t_enable;
    logic [7:0] d, w;
    wr(4'd1, 8'h02);
    cs_lo; xfer(8'h55, d); cs_hi;
    rd(4'd7, d); chk("R8 rx disabled drops", d, 8'h00);
    wr(4'd1, 8'h01);
    rd(4'd9, w); wr(4'd0, 8'h99); rd(4'd9, d); chk("R8 tx disabled ignores write", d, w);
    cs_lo; xfer(8'h66, d); chk("R8 tx disabled sends status", d, 8'h5A); cs_hi;
    rd(4'd0, d); chk("R8 rx enabled receives", d, 8'h66);
    wr(4'd1, 8'h03);
  endtask

  task automatic t_ptr;
    logic [7:0] d;
    wr(4'd9, 8'h15); rd(4'd9, d); chk("R9 write pointer readback", d, 8'h15);
    wr(4'd8, 8'h15); rd(4'd8, d); chk("R9 read pointer readback", d, 8'h15);
    wr(4'd0, 8'h77); rd(4'd9, d); chk("R9 write pointer advances", d, 8'h16);
    cs_lo; xfer(8'h00, d); chk("R9 send from set pointer", d, 8'h77); cs_hi;
    drain;
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    wr(4'd5, 8'h3E);
    cs_lo;
    for (int k = 0; k < 65; k++) xfer(8'(k), d);
    cs_hi;
    rd(4'd7, d); chk("R10 rx holds 64", d, 8'h40);
    rd(4'd4, d); chk("R10 rx overflow flag", d & 8'h04, 8'h04);
    for (int k = 0; k < 64; k++) begin
      rd(4'd0, d);
      if (k == 0)  chk("R10 first byte kept", d, 8'h00);
      if (k == 63) chk("R10 last stored byte", d, 8'h3F);
    end
    rd(4'd4, d); chk("R10 no underflow yet", d & 8'h08, 8'h00);
    rd(4'd0, d);
    rd(4'd4, d); chk("R10 rx underflow flag", d & 8'h08, 8'h08);
    for (int k = 0; k < 65; k++) wr(4'd0, 8'(k));
    rd(4'd4, d); chk("R10 tx overflow flag", d & 8'h10, 8'h10);
    wr(4'd6, 8'h04);
    chk("R11 overflow irq", {7'd0, irq}, 8'h01);
    wr(4'd5, 8'h3E);
    rd(4'd4, d); chk("R10 flags cleared", d & 8'h3E, 8'h00);
    wr(4'd6, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_thresh;
    t_flush;
    t_cs_flag;
    t_partial;
    t_enable;
    t_ptr;
    t_ovf;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule